// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the address for each beat of a four-beat burst. When a cycle starts, it captures an external address. The low two bits become the start offset and the upper bits are held. The block then steps through the four offsets of the burst in one of two orders.

- With the order input high, the order is interleaved: the offset is the start XOR the beat index.
- With the order input low, the order is linear: the offset is the start plus the beat index, modulo four.

An active-low advance input moves the burst forward one beat. After the fourth beat the sequence wraps back to the start offset. A flag marks the fourth beat. The order input is meant to be tied statically; changing it in the middle of a burst is not supported.

A small state machine holds the beat position. Its states are:

- ST_IDLE: no burst has been loaded since reset.
- ST_BEAT0 to ST_BEAT3: the current beat index.

Its transitions are:

- LOAD: from any state to ST_BEAT0, taken when `load_i` is high.
- STEP: ST_BEAT0 to ST_BEAT1, ST_BEAT1 to ST_BEAT2, ST_BEAT2 to ST_BEAT3.
- WRAP: ST_BEAT3 to ST_BEAT0.
- STALL: stay in the current state while `adv_n_i` is high.
- IDLE-HOLD: ST_IDLE stays in ST_IDLE without a load.

Top module: `burst_seq`

## Requirements
- R1: While reset is asserted and after it is released without a load, `offset_o` is 00, `last_o` is 0 and `addr_o` is all zeros.
- R2: On an edge where `load_i` is high, the next `offset_o` equals `addr_i[1:0]` and the beat index becomes 0.
- R3: With `order_i` high (interleaved), beat k presents offset = start XOR k (e.g. start 01 gives 01,00,11,10).
- R4: With `order_i` low (linear), beat k presents offset = (start + k) mod 4 (e.g. start 10 gives 10,11,00,01).
- R5: On an edge without a load, the beat index advances by one when `adv_n_i` is low and holds when `adv_n_i` is high.
- R6: A load takes priority over an advance sampled on the same edge.
- R7: An advance from the fourth beat returns the burst to beat 0, which presents the start offset again.
- R8: `last_o` is high exactly when the beat index is 3.
- R9: Advances before the first load after reset have no effect: outputs stay at their reset values.
- R10: `addr_o[ADDR_W-1:2]` is captured from `addr_i` on a load and stays unchanged until the next load; `addr_o[1:0]` equals `offset_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Start a burst from `addr_i` |
| adv_n_i | input | 1 | Active-low advance to the next beat |
| order_i | input | 1 | Burst order: 1 interleaved, 0 linear |
| addr_i | input | ADDR_W | External start address |
| addr_o | output | ADDR_W | Held upper bits with current offset |
| offset_o | output | 2 | Current 2-bit burst offset |
| last_o | output | 1 | High on the fourth beat |

## Verification
Every result is due one clock after the edge that samples `load_i` or `adv_n_i`. One register stage stands between those inputs and the offset, the flag and the upper address. `order_i` reaches the offset combinationally.

The bench drives inputs on the falling edge and updates its reference model in the same step. It waits one rising edge and compares all three outputs on the following falling edge. Each comparison therefore lands exactly one register stage after its stimulus.

The bench sweeps all four start offsets in both orders. The sweep includes stalls, wraps, a load that coincides with an advance, and advances issued before any load.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
    localparam int OFS_W = 2;
    localparam int BEATS = 1 << OFS_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BEAT0,
        ST_BEAT1,
        ST_BEAT2,
        ST_BEAT3
    } beat_state_e;
endpackage

// File: rtl/burst_seq_fsm.sv
module burst_seq_fsm
    import burst_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             adv_n_i,
    output logic             active_o,
    output logic [OFS_W-1:0] beat_o,
    output logic             last_o
);
    beat_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (load_i) begin
            state_d = ST_BEAT0;
        end else if (!adv_n_i) begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_BEAT0: state_d = ST_BEAT1;
                ST_BEAT1: state_d = ST_BEAT2;
                ST_BEAT2: state_d = ST_BEAT3;
                ST_BEAT3: state_d = ST_BEAT0;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        active_o = 1'b1;
        beat_o   = '0;
        last_o   = 1'b0;
        unique case (state_q)
            ST_IDLE:  active_o = 1'b0;
            ST_BEAT0: beat_o   = 2'd0;
            ST_BEAT1: beat_o   = 2'd1;
            ST_BEAT2: beat_o   = 2'd2;
            ST_BEAT3: begin
                beat_o = 2'd3;
                last_o = 1'b1;
            end
            default:  active_o = 1'b0;
        endcase
    end

    // R5: with no load and no advance, the state holds
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && adv_n_i) |=> (state_q == $past(state_q)));

    // R7: an advance from the last beat returns to the first
    a_r7_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BEAT3 && !load_i && !adv_n_i) |=> (state_q == ST_BEAT0));

    // R9: before any load, advances leave the machine idle
    a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !load_i) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/burst_seq_capture.sv
module burst_seq_capture
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [OFS_W-1:0]  start_o,
    output logic [ADDR_W-OFS_W-1:0] upper_o
);
    localparam int UP_W = ADDR_W - OFS_W;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_o <= '0;
            upper_o <= '0;
        end else if (load_i) begin
            start_o <= addr_i[OFS_W-1:0];
            upper_o <= addr_i[ADDR_W-1:OFS_W];
        end
    end

    // R10: upper bits only change on a load
    a_r10_upper_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(upper_o));

    initial begin
        if (UP_W < 1) $error("ADDR_W must exceed the offset width");
    end
endmodule

// File: rtl/burst_seq_order.sv
module burst_seq_order
    import burst_seq_pkg::*;
(
    input  logic             order_i,
    input  logic [OFS_W-1:0] start_i,
    input  logic [OFS_W-1:0] beat_i,
    output logic [OFS_W-1:0] ofs_o
);
    logic [OFS_W-1:0] lin_ofs;
    logic [OFS_W-1:0] ilv_ofs;

    always_comb begin
        lin_ofs = start_i + beat_i;
        ilv_ofs = start_i ^ beat_i;
        ofs_o   = order_i ? ilv_ofs : lin_ofs;
    end
endmodule

// File: rtl/burst_seq.sv
module burst_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              adv_n_i,
    input  logic              order_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [1:0]        offset_o,
    output logic              last_o
);
    localparam int UP_W = ADDR_W - OFS_W;

    logic             active;
    logic [OFS_W-1:0] beat;
    logic [OFS_W-1:0] start;
    logic [UP_W-1:0]  upper;
    logic [OFS_W-1:0] ofs;

    burst_seq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load_i),
        .adv_n_i  (adv_n_i),
        .active_o (active),
        .beat_o   (beat),
        .last_o   (last_o)
    );

    burst_seq_capture #(.ADDR_W(ADDR_W)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_i),
        .addr_i  (addr_i),
        .start_o (start),
        .upper_o (upper)
    );

    burst_seq_order u_order (
        .order_i (order_i),
        .start_i (start),
        .beat_i  (beat),
        .ofs_o   (ofs)
    );

    assign offset_o = ofs;
    assign addr_o   = {upper, ofs};

    // R2 and R6: the cycle after a load shows the loaded offset on beat 0
    a_r2_load_first: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (offset_o == $past(addr_i[OFS_W-1:0]) && !last_o));

    // R4: in linear order each advance adds one modulo four
    a_r4_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !load_i && !adv_n_i && !order_i && $stable(order_i))
            |=> (offset_o == $past(offset_o) + 2'd1));

    // R8: the flag is never high outside a loaded burst
    a_r8_last_active: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> active);
endmodule

// File: tb/burst_seq_tb.sv
module burst_seq_tb;
    localparam int AW = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load = 1'b0;
    logic          adv_n = 1'b1;
    logic          order = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [AW-1:0] addr_o;
    logic [1:0]    offset_o;
    logic          last_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    int m_start = 0;
    int m_k     = 0;
    int m_act   = 0;
    int m_up    = 0;

    always #4 clk = ~clk;

    burst_seq #(.ADDR_W(AW)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .adv_n_i  (adv_n),
        .order_i  (order),
        .addr_i   (addr),
        .addr_o   (addr_o),
        .offset_o (offset_o),
        .last_o   (last_o)
    );

    function automatic int exp_ofs();
        if (!m_act) return 0;
        if (order)  return m_start ^ m_k;
        return (m_start + m_k) % 4;
    endfunction

    task automatic compare(input string tag);
        int eo = exp_ofs();
        int el = (m_act && m_k == 3) ? 1 : 0;
        int ea = (m_up << 2) | eo;
        n_tests++;
        if (offset_o != eo[1:0] || last_o != el[0] || addr_o != ea[AW-1:0]) begin
            n_fail++;
            $display("FAIL %s: ofs=%0d last=%0d addr=%0h expected ofs=%0d last=%0d addr=%0h",
                     tag, offset_o, last_o, addr_o, eo, el, ea);
        end
    endtask

    task automatic cyc(input logic ld, input logic adv, input logic [AW-1:0] a, input string tag);
        load = ld; adv_n = adv; addr = a;
        if (ld) begin
            m_start = int'(a[1:0]); m_k = 0; m_act = 1; m_up = int'(a[AW-1:2]);
        end else if (!adv && m_act) begin
            m_k = (m_k + 1) % 4;
        end
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        compare("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1 after release");
        // R9: advance with no burst loaded
        cyc(1'b0, 1'b0, 18'h3ffff, "R9 idle advance");
        cyc(1'b0, 1'b0, 18'h00001, "R9 idle advance");
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 4; s++) begin
                order = m[0];
                cyc(1'b1, 1'b1, {16'(16'h1a5 * (s + 1) + m), s[1:0]}, "R2 load");
                for (int i = 1; i <= 7; i++) begin
                    if (i == 3) cyc(1'b0, 1'b1, 18'h2aaaa, "R5 hold");
                    else cyc(1'b0, 1'b0, 18'h15555,
                             (m_k == 3) ? "R7 wrap" :
                             (m_k == 2) ? "R8 last beat" :
                             (m == 1) ? "R3 interleaved" : "R4 linear");
                end
            end
        end
        // R6: load wins over an advance on the same edge
        order = 1'b0;
        cyc(1'b1, 1'b1, 18'h0c002, "R2 load");
        cyc(1'b0, 1'b0, 18'h00000, "R4 linear");
        cyc(1'b1, 1'b0, 18'h3f003, "R6 load over advance");
        cyc(1'b0, 1'b0, 18'h1234c, "R10 upper held");
        cyc(1'b0, 1'b1, 18'h00000, "R10 upper held");
        order = 1'b1;
        cyc(1'b1, 1'b0, 18'h2b001, "R6 load over advance");
        cyc(1'b0, 1'b0, 18'h00000, "R3 interleaved");
        cyc(1'b0, 1'b0, 18'h00000, "R3 interleaved");
        cyc(1'b0, 1'b0, 18'h00000, "R8 last beat");
        cyc(1'b0, 1'b0, 18'h00000, "R7 wrap");
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule